// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block sits between a set of interrupt sources and a CPU core. It ranks eight maskable sources, one non-maskable source and one software trap, and tells the core which one to serve next. Every maskable source has a 3-bit code. Its rank is not stored with the source. Instead, eight priority slots each hold one source code, and the slot number is the rank. Software fills the slots through three byte-wide registers and enables sources through a byte-wide mask register.

Each request pulse sets a pending bit, and that bit holds until the request is served or cleared. A pending source is offered to the core when it is enabled and its rank is strictly above the level of the handler now running. A stack of active levels lets a higher-ranked source preempt a running handler, and a return strobe pops the stack back to the level beneath. The core can also drop one pending maskable request by its code without serving it. The non-maskable source and the trap sit above every slot, at fixed levels.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no request is pending, `irq` is low, no handler is active, the mask register is 0 (every source masked) and all priority slots hold code 0.
- R2: A write to address 0 loads the mask. Mask bit i set to 1 enables the source with code i. A request from a masked source is not granted, but it stays pending and is raised on `irq` as soon as its mask bit is set.
- R3: Addresses 2, 3 and 4 each load one byte of a 24-bit slot word {addr2, addr3, addr4}. Slot k occupies bits 3k+2 down to 3k, holds a source code, and gives that source level k+1. Among the eligible sources, the one with the highest level is presented on `irq_code` with `irq_kind` = 0.
- R4: A pending candidate raises `irq` only when its level is strictly above the level at the top of the active stack (0 with no handler). `ack` while `irq` is high pushes the granted level. `reti` pops one level and so restores the level of the interrupted handler.
- R5: The non-maskable request ignores the mask register and has level 9, above every slot. It is presented with `irq_kind` = 1 and `irq_code` = 0.
- R6: The trap has level 10 and is presented with `irq_kind` = 2, even when `int_en` is low. Nothing preempts a running trap handler, including another trap.
- R7: While `int_en` is low, no maskable or non-maskable request is granted, but every request stays pending.
- R8: `clr_en` with `clr_code` removes the pending request of that maskable code without serving it, and it leaves the other pending requests untouched.
- R9: Writes to addresses 2 to 4 are ignored while any handler is active. Mask writes always take effect.
- R10: `ack` clears the pending bit of the granted source. A new request from the same source in the same cycle keeps that bit set.
- R11: A source whose code is in no slot is never granted. When a code is in several slots, it takes the level of the highest of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 mask, 2..4 priority slots) |
| wr_data | input | 8 | Register write data |
| int_en | input | 1 | Global enable for maskable and non-maskable requests |
| src_req | input | 8 | Request pulses, bit i is the source with code i |
| nmi_req | input | 1 | Non-maskable request pulse |
| trap_req | input | 1 | Software trap request pulse |
| clr_en | input | 1 | Clear-pending command strobe |
| clr_code | input | 3 | Code of the source whose pending request is removed |
| ack | input | 1 | CPU acknowledge of the presented request |
| reti | input | 1 | Return from the current handler |
| irq | output | 1 | Request to the CPU |
| irq_kind | output | 2 | 0 maskable, 1 non-maskable, 2 trap |
| irq_code | output | 3 | Code of the presented maskable source, 0 otherwise |

## Verification
The bench builds the block with its default parameters. These give eight 3-bit source codes, byte-wide registers and a ten-entry level stack, so every slot can be filled and the full chain can be reached: maskable, then non-maskable, then trap, with a nested trap held off. A vector table runs the winning-code logic under identity, reversed, all-zero and masked slot settings. Directed sequences then cover nesting and unwinding, writes frozen during a handler, same-cycle acknowledge and re-request, and clear by code.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      KIND_SRC  = 2'd0,
      KIND_NMI  = 2'd1,
      KIND_TRAP = 2'd2
   } irq_kind_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            pend_o[i] <= 1'b0;
         else if (set_i[i])     pend_o[i] <= 1'b1;
         else if (clr_i[i])     pend_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_rank.sv
module irq_rank
   import irq_pkg::*;
#(
   parameter int CODE_W = 3,
   parameter int LVL_W  = 4
) (
   input  logic [(1<<CODE_W)*CODE_W-1:0] slots_i,
   input  logic [(1<<CODE_W)-1:0]        elig_i,
   input  logic                          nmi_elig_i,
   input  logic                          trap_elig_i,
   output logic [LVL_W-1:0]              lvl_o,
   output logic [CODE_W-1:0]             code_o,
   output irq_kind_e                     kind_o
);
   localparam int NUM_SRC  = 1 << CODE_W;
   localparam int NMI_LVL  = NUM_SRC + 1;
   localparam int TRAP_LVL = NUM_SRC + 2;

   always_comb begin
      lvl_o  = '0;
      code_o = '0;
      kind_o = KIND_SRC;
      // ascending scan: a later (higher) slot overrides a lower one
      for (int k = 0; k < NUM_SRC; k++) begin
         if (elig_i[slots_i[k*CODE_W +: CODE_W]]) begin
            lvl_o  = LVL_W'(k + 1);
            code_o = slots_i[k*CODE_W +: CODE_W];
         end
      end
      if (nmi_elig_i) begin
         lvl_o  = LVL_W'(NMI_LVL);
         code_o = '0;
         kind_o = KIND_NMI;
      end
      if (trap_elig_i) begin
         lvl_o  = LVL_W'(TRAP_LVL);
         code_o = '0;
         kind_o = KIND_TRAP;
      end
   end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
   parameter int LVL_W = 4,
   parameter int DEPTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic [LVL_W-1:0] top_o,
   output logic             busy_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [LVL_W-1:0] ent_q [DEPTH];
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else if (push_i && cnt_q < CNT_W'(DEPTH)) begin
         ent_q[cnt_q] <= lvl_i;
         cnt_q        <= cnt_q + 1'b1;
      end else if (pop_i && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign top_o  = busy_o ? ent_q[cnt_q - 1'b1] : '0;

   // R4: strictly rising levels bound nesting depth to the level count
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> cnt_q < CNT_W'(DEPTH));
   a_r4_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && cnt_q > CNT_W'(1)) |=> top_o == $past(ent_q[cnt_q - 2'd2]));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_pkg::*;
#(
   parameter int CODE_W       = 3,
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 3,
   parameter int MASK_ADDR    = 0,
   parameter int PRIO_ADDR_HI = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   int_en,
   input  logic [(1<<CODE_W)-1:0] src_req,
   input  logic                   nmi_req,
   input  logic                   trap_req,
   input  logic                   clr_en,
   input  logic [CODE_W-1:0]      clr_code,
   input  logic                   ack,
   input  logic                   reti,
   output logic                   irq,
   output logic [1:0]             irq_kind,
   output logic [CODE_W-1:0]      irq_code
);
   localparam int NUM_SRC   = 1 << CODE_W;
   localparam int PRIO_BITS = NUM_SRC * CODE_W;
   localparam int PRIO_REGS = PRIO_BITS / DATA_W;
   localparam int NMI_LVL   = NUM_SRC + 1;
   localparam int TRAP_LVL  = NUM_SRC + 2;
   localparam int LVL_W     = $clog2(TRAP_LVL + 1);
   localparam int NPEND     = NUM_SRC + 2;
   localparam int NMI_BIT   = NUM_SRC;
   localparam int TRAP_BIT  = NUM_SRC + 1;

   if (PRIO_BITS % DATA_W != 0) begin : g_bad_split
      $error("slot word must split into whole registers");
   end
   if (DATA_W < NUM_SRC) begin : g_bad_mask
      $error("mask register narrower than source count");
   end
   if (PRIO_ADDR_HI + PRIO_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("priority registers exceed address space");
   end

   logic [NUM_SRC-1:0]   mask_q;
   logic [PRIO_BITS-1:0] prio_q;
   logic [NPEND-1:0]     pend, pend_set, pend_clr;
   logic [LVL_W-1:0]     best_lvl, top_lvl;
   logic [CODE_W-1:0]    best_code;
   irq_kind_e            best_kind;
   logic                 busy, push;

   // mask register: always writable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                           mask_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(MASK_ADDR))      mask_q <= wr_data[NUM_SRC-1:0];
   end

   // slot registers: first address holds the most significant byte
   for (genvar r = 0; r < PRIO_REGS; r++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q[PRIO_BITS-1-r*DATA_W -: DATA_W] <= '0;
         else if (wr_en && !busy && wr_addr == ADDR_W'(PRIO_ADDR_HI + r))
            prio_q[PRIO_BITS-1-r*DATA_W -: DATA_W] <= wr_data;
      end
   end

   assign pend_set = {trap_req, nmi_req, src_req};

   always_comb begin
      pend_clr = '0;
      if (clr_en) pend_clr[clr_code] = 1'b1;
      if (push) begin
         case (best_kind)
            KIND_NMI:  pend_clr[NMI_BIT]   = 1'b1;
            KIND_TRAP: pend_clr[TRAP_BIT]  = 1'b1;
            default:   pend_clr[best_code] = 1'b1;
         endcase
      end
   end

   irq_pending #(.N(NPEND)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pend_set),
      .clr_i  (pend_clr),
      .pend_o (pend)
   );

   irq_rank #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_rank (
      .slots_i     (prio_q),
      .elig_i      (pend[NUM_SRC-1:0] & mask_q & {NUM_SRC{int_en}}),
      .nmi_elig_i  (pend[NMI_BIT] & int_en),
      .trap_elig_i (pend[TRAP_BIT]),
      .lvl_o       (best_lvl),
      .code_o      (best_code),
      .kind_o      (best_kind)
   );

   irq_lvl_stack #(.LVL_W(LVL_W), .DEPTH(TRAP_LVL)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push),
      .pop_i  (reti && !push),
      .lvl_i  (best_lvl),
      .top_o  (top_lvl),
      .busy_o (busy)
   );

   assign irq      = best_lvl > top_lvl;
   assign push     = ack && irq;
   assign irq_kind = irq ? best_kind : KIND_SRC;
   assign irq_code = (irq && best_kind == KIND_SRC) ? best_code : '0;

   // R2, R7: a maskable grant needs its mask bit and the global enable
   a_r2_masked_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && irq_kind == KIND_SRC) |-> (mask_q[irq_code] && int_en));
   // R4: an acknowledge raises the active level
   a_r4_push_rises: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top_lvl > $past(top_lvl));
   // R5: a pending enabled non-maskable request beats every slot
   a_r5_nmi_over_slots: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[NMI_BIT] && int_en && !pend[TRAP_BIT] && top_lvl < LVL_W'(NMI_LVL))
      |-> (irq && irq_kind == KIND_NMI));
   // R6: a pending trap is presented unless a trap handler runs
   a_r6_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[TRAP_BIT] && top_lvl != LVL_W'(TRAP_LVL)) |-> (irq && irq_kind == KIND_TRAP));
   // R9: slot word frozen while a handler is active
   a_r9_prio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(prio_q));
   // R10: acknowledge without a new request drops the pending bit
   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (push && irq_kind == KIND_SRC && !src_req[irq_code]) |=> !pend[$past(irq_code)]);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       int_en = 1'b1;
   logic [7:0] src_req = '0;
   logic       nmi_req = 1'b0;
   logic       trap_req = 1'b0;
   logic       clr_en = 1'b0;
   logic [2:0] clr_code = '0;
   logic       ack = 1'b0;
   logic       reti = 1'b0;
   logic       irq;
   logic [1:0] irq_kind;
   logic [2:0] irq_code;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .int_en, .src_req,
      .nmi_req, .trap_req, .clr_en, .clr_code, .ack, .reti,
      .irq, .irq_kind, .irq_code
   );

   typedef struct packed {
      logic [23:0] prio;
      logic [7:0]  mask;
      logic [7:0]  req;
      logic        exp_irq;
      logic [2:0]  exp_code;
   } vec_t;

   localparam logic [23:0] P_IDENT = 24'hFAC688; // slot k holds code k
   localparam logic [23:0] P_REV   = 24'h053977; // slot k holds code 7-k

   localparam vec_t VECS [8] = '{
      '{P_IDENT,  8'hFF, 8'h05, 1'b1, 3'd2},
      '{P_REV,    8'hFF, 8'h05, 1'b1, 3'd0},
      '{P_IDENT,  8'hFB, 8'h05, 1'b1, 3'd0},
      '{P_IDENT,  8'hFF, 8'h80, 1'b1, 3'd7},
      '{P_REV,    8'hFE, 8'h81, 1'b1, 3'd7},
      '{P_IDENT,  8'h00, 8'hFF, 1'b0, 3'd0},
      '{24'h0,    8'hFF, 8'h03, 1'b1, 3'd0},
      '{24'h0,    8'hFF, 8'h02, 1'b0, 3'd0}
   };

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_prio(input logic [23:0] p);
      wr(3'd2, p[23:16]); wr(3'd3, p[15:8]); wr(3'd4, p[7:0]);
   endtask

   task automatic req(input logic [7:0] r);
      src_req = r; @(negedge clk); src_req = '0;
   endtask

   task automatic clr(input logic [2:0] c);
      clr_en = 1'b1; clr_code = c; @(negedge clk); clr_en = 1'b0;
   endtask

   task automatic do_ack;
      ack = 1'b1; @(negedge clk); ack = 1'b0;
   endtask

   task automatic do_reti;
      reti = 1'b1; @(negedge clk); reti = 1'b0;
   endtask

   task automatic do_nmi;
      nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0;
   endtask

   task automatic do_trap;
      trap_req = 1'b1; @(negedge clk); trap_req = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq, 0, "R1 irq low after reset");
      wr_prio(P_IDENT);
      req(8'h10);
      chk(irq, 0, "R1 mask resets to all masked");
      wr(3'd0, 8'h10);
      chk(irq, 1, "R2 unmask raises held request");
      chk(irq_code, 4, "R2 unmasked code");
      clr(3'd4);
      chk(irq, 0, "R8 clear drops pending");

      for (int i = 0; i < 8; i++) begin
         wr_prio(VECS[i].prio);
         wr(3'd0, VECS[i].mask);
         req(VECS[i].req);
         chk(irq, int'(VECS[i].exp_irq), $sformatf("R3 R11 vector %0d irq", i));
         if (VECS[i].exp_irq)
            chk(irq_code, int'(VECS[i].exp_code), $sformatf("R3 R11 vector %0d code", i));
         for (int c = 0; c < 8; c++) clr(3'(c));
      end

      wr_prio(P_IDENT);
      wr(3'd0, 8'h00);
      req(8'h10);
      clr(3'd4);
      wr(3'd0, 8'hFF);
      chk(irq, 0, "R8 cleared while masked stays gone");
      req(8'h0C);
      clr(3'd3);
      chk(irq_code, 2, "R8 clear leaves other codes");
      do_ack;
      do_reti;
      chk(irq, 0, "R10 ack cleared pending");

      // nesting
      req(8'h08);
      chk(irq_code, 3, "R4 first grant");
      do_ack;
      chk(irq, 0, "R4 no grant at same level");
      req(8'h02);
      chk(irq, 0, "R4 lower level blocked");
      req(8'h20);
      chk(irq, 1, "R4 higher level preempts");
      chk(irq_code, 5, "R4 preempting code");
      do_ack;
      do_reti;
      chk(irq, 0, "R4 pop restores level of code 3");
      do_reti;
      chk(irq_code, 1, "R4 lower served after unwinding");
      chk(irq, 1, "R4 irq after unwinding");

      // global enable and non-maskable
      int_en = 1'b0; #1;
      chk(irq, 0, "R7 disable blocks maskable");
      do_nmi;
      chk(irq, 0, "R7 disable blocks non-maskable");
      int_en = 1'b1; #1;
      chk(irq_kind, 1, "R5 non-maskable over slots");
      chk(irq_code, 0, "R5 code zero for non-maskable");
      do_ack;
      chk(irq, 0, "R5 slots below non-maskable level");

      // trap
      int_en = 1'b0;
      do_trap;
      chk(irq_kind, 2, "R6 trap with enable low");
      chk(irq, 1, "R6 trap irq");
      do_ack;
      int_en = 1'b1;
      do_nmi;
      req(8'h80);
      chk(irq, 0, "R6 trap handler not preempted");
      do_trap;
      chk(irq, 0, "R6 trap does not preempt trap");
      do_reti;
      chk(irq_kind, 2, "R6 pending trap after return");
      do_ack;
      do_reti;
      do_reti;
      chk(irq_kind, 1, "R5 held non-maskable served");
      do_ack;
      do_reti;
      chk(irq_code, 7, "R3 highest slot after unwinding");
      clr(3'd7);
      clr(3'd1);
      chk(irq, 0, "R8 all cleared");

      // same-cycle acknowledge and re-request
      req(8'h04);
      src_req = 8'h04; ack = 1'b1;
      @(negedge clk);
      src_req = '0; ack = 1'b0;
      chk(irq, 0, "R10 same level blocked while active");
      do_reti;
      chk(irq_code, 2, "R10 re-request kept pending");
      chk(irq, 1, "R10 irq after return");
      clr(3'd2);

      // frozen slot writes during a handler
      req(8'h08);
      do_ack;
      wr_prio(P_REV);
      wr(3'd0, 8'h7F);
      do_reti;
      req(8'h81);
      chk(irq_code, 0, "R9 mask write accepted in handler");
      wr(3'd0, 8'hFF);
      chk(irq_code, 7, "R9 slot write ignored in handler");
      wr_prio(P_REV);
      chk(irq_code, 0, "R3 slot write accepted when idle");
      clr(3'd0);
      clr(3'd7);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule